// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the programmable state of a small I/O address-translation unit that serves several independent translation contexts. Each context occupies its own 64-byte window of 32-bit words on a simple word-addressed read/write bus. The window holds an enable/control word, the translation-table base (low and high halves), a table-format control word, a bus-attribute word, a memory-attribute indirection word, a fault status word and the address of the first fault. Software programs a context through these words, starts a TLB invalidation by setting a flush bit, and services faults by reading status and address and then writing zero to status.

Toward the rest of the translation unit the bank exposes one enable per context, a flush request per context, and a fault capture port. The flush request stays high from the write that starts it until the TLB returns a one-cycle done pulse for that context, and the flush bit reads back as 1 for that whole time. Fault events from the translation datapath are logged into the status of the addressed context. A single level-sensitive interrupt line summarises all contexts.

Top module: `xmmu_ctx_bank`

## Requirements
- R1: After reset every word of every context reads 0, and `irq`, `flush_req` and `ctx_enable` are all 0.
- R2: Context n occupies words n*16 to n*16+15 (`bus_addr` is a word address). Word offsets 2 (table control), 3 (bus attributes), 4 (table base low), 5 (table base high) and 10 (attribute indirection) are plain 32-bit read/write registers.
- R3: Word offsets 1, 6, 7, 9, 11, 13, 14 and 15 read 0, and writes to them change nothing.
- R4: The control word sits at offset 0: bit 0 enables translation and drives `ctx_enable[n]` from the cycle after the write, bit 2 enables the interrupt, and all other bits read 0. Writing 0 clears enable and interrupt enable.
- R5: Writing control with bit 1 set raises `flush_req[n]` the next cycle and bit 1 reads 1 while it is high. It drops the cycle after a `flush_done[n]` pulse. A control write with bit 1 clear does not cancel a pending flush, and a second flush written while one is pending merges into it, so one done pulse ends both.
- R6: The status word is at offset 8. A fault event (`fault_valid` with `fault_ctx`) is visible the next cycle. `fault_type` bits 0, 1, 2 and 3 (translation fault, page fault, walk abort, multiple TLB hit) appear at status bits 0, 1, 2 and 4; `fault_code` appears at bits 10:8 and `fault_level` at bits 13:12.
- R7: When a fault reaches a context whose status flags are already non-zero, only its type bits are OR-ed into the flags; the stored code, level and fault address are kept.
- R8: Writing 0 to status clears the flags, code, level and the fault address; writing any non-zero value changes nothing. A zero write and a fault in the same cycle leave the new fault captured as a first fault.
- R9: Offset 12 reads the address of the first fault and ignores writes.
- R10: `irq` is high exactly when some context has interrupt enable set and at least one of its status flags set.
- R11: A fault event whose `fault_type` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W (6) | Word address: context index above, word offset below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| ctx_enable | output | NUM_CTX (4) | Translation enable per context |
| flush_req | output | NUM_CTX (4) | TLB invalidation request per context |
| flush_done | input | NUM_CTX (4) | One-cycle invalidation complete pulse per context |
| fault_valid | input | 1 | Fault event strobe |
| fault_ctx | input | CTX_W (2) | Context of the fault |
| fault_type | input | 4 | Fault kind flags |
| fault_code | input | 3 | Error code (1 table format, 4 access permission, 5 secure access) |
| fault_level | input | 2 | Table level of the fault |
| fault_addr | input | 32 | Faulting input address |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The bench uses the default build of four contexts with a 64-byte window, which makes the whole 64-word address space small enough to sweep: every word is read after reset, written with an address-derived pattern and read back. Every non-zero fault type is injected into every context, followed by a second overlapping fault, a rejected non-zero clear and a zero clear, so first-fault retention and the OR of later flags are checked against arithmetic expectations. Flush merging, a disabling write during a pending flush, a same-cycle clear and fault, and interrupt masking are driven as directed sequences.

// File: rtl/xmmu_ctx_pkg.sv
package xmmu_ctx_pkg;

    localparam int WORD_W = 32;

    // Word offsets inside one context window
    localparam int OFF_CTRL    = 0;
    localparam int OFF_TBLCTL  = 2;
    localparam int OFF_BUSATTR = 3;
    localparam int OFF_BASE_LO = 4;
    localparam int OFF_BASE_HI = 5;
    localparam int OFF_STATUS  = 8;
    localparam int OFF_MEMATTR = 10;
    localparam int OFF_ERRADDR = 12;

    localparam int NUM_PLAIN = 5;

    typedef struct packed {
        logic irq_en;
        logic flush;
        logic xl_en;
    } ctl_t;

    typedef struct packed {
        logic [1:0] level;
        logic [2:0] code;
        logic [3:0] flags;   // {multi-hit, abort, page, translation}
    } stat_t;

    // Slot of a plain register, or -1 when the offset is not one
    function automatic int plain_slot(input int off);
        case (off)
            OFF_TBLCTL:  return 0;
            OFF_BUSATTR: return 1;
            OFF_BASE_LO: return 2;
            OFF_BASE_HI: return 3;
            OFF_MEMATTR: return 4;
            default:     return -1;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input stat_t s);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[13:12]  = s.level;
        w[10:8]   = s.code;
        w[4]      = s.flags[3];
        w[2:0]    = s.flags[2:0];
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctl(input ctl_t c);
        logic [WORD_W-1:0] w;
        w      = '0;
        w[2]   = c.irq_en;
        w[1]   = c.flush;
        w[0]   = c.xl_en;
        return w;
    endfunction

endpackage

// File: rtl/xmmu_ctx_slice.sv
module xmmu_ctx_slice
    import xmmu_ctx_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              flush_done,
    output logic              flush_pend,
    output logic              xl_en,
    input  logic              fault_hit,
    input  logic [3:0]        fault_type,
    input  logic [2:0]        fault_code,
    input  logic [1:0]        fault_level,
    input  logic [WORD_W-1:0] fault_addr,
    output logic              irq_req
);

    ctl_t              ctl_q, ctl_d;
    stat_t             stat_q, stat_d;
    logic [WORD_W-1:0] err_q, err_d;
    logic [WORD_W-1:0] plain_q [NUM_PLAIN];

    logic wr_ctrl, wr_stat_clr, flt;
    int   slot;

    assign slot        = plain_slot(int'(off));
    assign wr_ctrl     = wr_hit && (int'(off) == OFF_CTRL);
    assign wr_stat_clr = wr_hit && (int'(off) == OFF_STATUS) && (wr_data == '0);
    assign flt         = fault_hit && (fault_type != 4'b0);

    // control and flush handshake: a new flush request wins over done
    always_comb begin
        ctl_d = ctl_q;
        if (flush_done)
            ctl_d.flush = 1'b0;
        if (wr_ctrl) begin
            ctl_d.xl_en  = wr_data[0];
            ctl_d.irq_en = wr_data[2];
            if (wr_data[1])
                ctl_d.flush = 1'b1;
        end
    end

    // fault logging: clear first, then first-fault capture or flag merge
    always_comb begin
        stat_t             base_s;
        logic [WORD_W-1:0] base_a;
        base_s = wr_stat_clr ? '0 : stat_q;
        base_a = wr_stat_clr ? '0 : err_q;
        stat_d = base_s;
        err_d  = base_a;
        if (flt) begin
            if (base_s.flags == 4'b0) begin
                stat_d.flags = fault_type;
                stat_d.code  = fault_code;
                stat_d.level = fault_level;
                err_d        = fault_addr;
            end else begin
                stat_d.flags = base_s.flags | fault_type;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            stat_q <= '0;
            err_q  <= '0;
        end else begin
            ctl_q  <= ctl_d;
            stat_q <= stat_d;
            err_q  <= err_d;
        end
    end

    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst)
                plain_q[g] <= '0;
            else if (wr_hit && slot == g)
                plain_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (slot >= 0)
            rd_data = plain_q[slot];
        else if (int'(off) == OFF_CTRL)
            rd_data = pack_ctl(ctl_q);
        else if (int'(off) == OFF_STATUS)
            rd_data = pack_status(stat_q);
        else if (int'(off) == OFF_ERRADDR)
            rd_data = err_q;
    end

    assign flush_pend = ctl_q.flush;
    assign xl_en      = ctl_q.xl_en;
    assign irq_req    = ctl_q.irq_en && (stat_q.flags != 4'b0);

endmodule

// File: rtl/xmmu_rd_mux.sv
module xmmu_rd_mux
    import xmmu_ctx_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2
) (
    input  logic [WORD_W-1:0] words [NUM_CTX],
    input  logic [CTX_W-1:0]  sel,
    output logic [WORD_W-1:0] word_out
);

    always_comb begin
        word_out = '0;
        for (int i = 0; i < NUM_CTX; i++)
            if (int'(sel) == i)
                word_out = words[i];
    end

endmodule

// File: rtl/xmmu_irq_merge.sv
module xmmu_irq_merge #(
    parameter int NUM_CTX = 4
) (
    input  logic [NUM_CTX-1:0] req,
    output logic               irq
);

    assign irq = |req;

endmodule

// File: rtl/xmmu_ctx_bank.sv
module xmmu_ctx_bank
    import xmmu_ctx_pkg::*;
#(
    parameter int NUM_CTX   = 4,
    parameter int WIN_BYTES = 64,
    localparam int OFF_W    = $clog2(WIN_BYTES / 4),
    localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int ADDR_W   = CTX_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CTX-1:0] ctx_enable,
    output logic [NUM_CTX-1:0] flush_req,
    input  logic [NUM_CTX-1:0] flush_done,
    input  logic               fault_valid,
    input  logic [CTX_W-1:0]   fault_ctx,
    input  logic [3:0]         fault_type,
    input  logic [2:0]         fault_code,
    input  logic [1:0]         fault_level,
    input  logic [31:0]        fault_addr,
    output logic               irq
);

    logic [CTX_W-1:0]  ctx_sel;
    logic [OFF_W-1:0]  off;
    logic [WORD_W-1:0] ctx_words [NUM_CTX];
    logic [NUM_CTX-1:0] irq_req;

    assign ctx_sel = bus_addr[ADDR_W-1:OFF_W];
    assign off     = bus_addr[OFF_W-1:0];

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        xmmu_ctx_slice #(.OFF_W(OFF_W)) u_slice (
            .clk         (clk),
            .rst         (rst),
            .wr_hit      (bus_wr && int'(ctx_sel) == c),
            .off         (off),
            .wr_data     (bus_wdata),
            .rd_data     (ctx_words[c]),
            .flush_done  (flush_done[c]),
            .flush_pend  (flush_req[c]),
            .xl_en       (ctx_enable[c]),
            .fault_hit   (fault_valid && int'(fault_ctx) == c),
            .fault_type  (fault_type),
            .fault_code  (fault_code),
            .fault_level (fault_level),
            .fault_addr  (fault_addr),
            .irq_req     (irq_req[c])
        );
    end

    xmmu_rd_mux #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_rd_mux (
        .words    (ctx_words),
        .sel      (ctx_sel),
        .word_out (bus_rdata)
    );

    xmmu_irq_merge #(.NUM_CTX(NUM_CTX)) u_irq (
        .req (irq_req),
        .irq (irq)
    );

endmodule

// File: rtl/xmmu_ctx_bank_chk.sv
module xmmu_ctx_bank_chk #(
    parameter int NUM_CTX = 4,
    parameter int OFF_W   = 4,
    parameter int CTX_W   = 2,
    parameter int ADDR_W  = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_CTX-1:0] ctx_enable,
    input logic [NUM_CTX-1:0] flush_req,
    input logic [NUM_CTX-1:0] flush_done,
    input logic               fault_valid,
    input logic [CTX_W-1:0]   fault_ctx,
    input logic [3:0]         fault_type,
    input logic [2:0]         fault_code,
    input logic [1:0]         fault_level,
    input logic [31:0]        fault_addr,
    input logic               irq
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (irq == 1'b0 && flush_req == '0 && ctx_enable == '0));

    // R4
    enable_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctx_enable) |-> $past(bus_wr));

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(bus_wr));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(bus_wr || fault_valid));

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_flush
        // R5
        flush_end_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(flush_req[i]) |-> $past(flush_done[i]));
        // R5
        flush_start_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(flush_req[i]) |->
                $past(bus_wr && bus_wdata[1] && bus_addr == ADDR_W'(i << OFF_W)));
    end

endmodule

bind xmmu_ctx_bank xmmu_ctx_bank_chk #(
    .NUM_CTX (NUM_CTX),
    .OFF_W   (OFF_W),
    .CTX_W   (CTX_W),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/tb_xmmu_ctx_bank.sv
module tb_xmmu_ctx_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NC     = 4;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC-1:0]     ctx_enable, flush_req;
    logic [NC-1:0]     flush_done = '0;
    logic              fault_valid = 1'b0;
    logic [1:0]        fault_ctx = '0;
    logic [3:0]        fault_type = '0;
    logic [2:0]        fault_code = '0;
    logic [1:0]        fault_level = '0;
    logic [31:0]       fault_addr = '0;
    logic              irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmmu_ctx_bank dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk); #1;
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = ADDR_W'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic flt(input int c, input logic [3:0] t, input logic [2:0] code,
                       input logic [1:0] lvl, input logic [31:0] a);
        fault_ctx   = 2'(c);
        fault_type  = t;
        fault_code  = code;
        fault_level = lvl;
        fault_addr  = a;
        fault_valid = 1'b1;
        @(posedge clk); #1;
        fault_valid = 1'b0;
    endtask

    function automatic logic [31:0] pat(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {8'hA0 ^ b, ~b, 8'h5A + b, b ^ {4'h0, b[7:4]}};
    endfunction

    function automatic logic [31:0] sexp(input logic [3:0] t, input logic [2:0] code,
                                         input logic [1:0] lvl);
        return (32'(lvl) << 12) | (32'(code) << 8) | (32'(t[3]) << 4) | 32'(t[2:0]);
    endfunction

    function automatic bit is_plain(input int o);
        return o == 2 || o == 3 || o == 4 || o == 5 || o == 10;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_w;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: every word reads 0 after reset
        for (int a = 0; a < NC*16; a++) begin
            rd(a, v);
            chk("R1 reset word", v, 32'h0);
        end
        chk("R1 irq", 32'(irq), 0);
        chk("R1 flush_req", 32'(flush_req), 0);
        chk("R1 ctx_enable", 32'(ctx_enable), 0);

        // R2 R3 R4 R8 R9: write every word with a pattern, read all back
        for (int a = 0; a < NC*16; a++) wr(a, pat(a));
        for (int a = 0; a < NC*16; a++) begin
            int o;
            o = a % 16;
            rd(a, v);
            if (is_plain(o))      exp_w = pat(a);           // R2
            else if (o == 0)      exp_w = pat(a) & 32'h7;   // R4
            else                  exp_w = 32'h0;            // R3, R8, R9
            chk($sformatf("R2/R3 word %0d", a), v, exp_w);
        end
        for (int c = 0; c < NC; c++) begin
            v = pat(c*16);
            chk("R4 ctx_enable bit", 32'(ctx_enable[c]), 32'(v[0]));
            chk("R5 flush_req bit", 32'(flush_req[c]), 32'(v[1]));
        end

        // R5: disabling write keeps flush, merged flush, done pulses
        wr(2*16, 32'h0);
        chk("R4 disable ctx2", 32'(ctx_enable[2]), 0);
        chk("R5 no cancel", 32'(flush_req), 32'b1100);
        rd(2*16, v);
        chk("R5 ctrl reads flush", v, 32'h2);
        wr(3*16, 32'h2);
        chk("R5 merge", 32'(flush_req), 32'b1100);
        flush_done = 4'b1000;
        @(posedge clk); #1;
        flush_done = '0;
        chk("R5 one done ends merged", 32'(flush_req), 32'b0100);
        rd(3*16, v);
        chk("R5 ctrl bit cleared", v, 32'h0);
        flush_done = 4'b0100;
        @(posedge clk); #1;
        flush_done = '0;
        chk("R5 ctx2 done", 32'(flush_req), 0);

        // R6 R7 R8 R9 R10: every fault type into every context
        for (int c = 0; c < NC; c++) begin
            for (int t = 1; t < 16; t++) begin
                logic [3:0]  t2;
                logic [2:0]  code;
                logic [1:0]  lvl;
                logic [31:0] a1;
                code = (t % 3 == 0) ? 3'd1 : ((t % 3 == 1) ? 3'd4 : 3'd5);
                lvl  = 2'(t % 4);
                a1   = 32'h1000_0000 + 32'(c) * 32'h100 + 32'(t) * 4;
                t2   = ~4'(t);
                if (t2 == 0) t2 = 4'h1;
                wr(c*16, 32'h4);
                flt(c, 4'(t), code, lvl, a1);
                rd(c*16 + 8, v);
                chk("R6 status capture", v, sexp(4'(t), code, lvl));
                rd(c*16 + 12, v);
                chk("R9 error address", v, a1);
                chk("R10 irq on", 32'(irq), 1);
                flt(c, t2, ~code, ~lvl, a1 + 32'h40);
                rd(c*16 + 8, v);
                chk("R7 flags OR, code kept", v, sexp(4'(t) | t2, code, lvl));
                rd(c*16 + 12, v);
                chk("R7 address kept", v, a1);
                wr(c*16 + 8, 32'h13);
                wr(c*16 + 12, 32'hDEAD_0000);
                rd(c*16 + 8, v);
                chk("R8 nonzero write ignored", v, sexp(4'(t) | t2, code, lvl));
                rd(c*16 + 12, v);
                chk("R9 write ignored", v, a1);
                wr(c*16 + 8, 32'h0);
                rd(c*16 + 8, v);
                chk("R8 status cleared", v, 32'h0);
                rd(c*16 + 12, v);
                chk("R8 address cleared", v, 32'h0);
                chk("R10 irq off", 32'(irq), 0);
            end
        end

        // R10: masked interrupt, then unmasked
        wr(16, 32'h0);
        flt(1, 4'h2, 3'd5, 2'd1, 32'h4444_0000);
        chk("R10 masked irq", 32'(irq), 0);
        rd(0 + 8, v);
        chk("R6 other context untouched", v, 32'h0);
        wr(16, 32'h4);
        chk("R10 unmask irq", 32'(irq), 1);

        // R8: zero write and fault in same cycle
        bus_addr    = ADDR_W'(16 + 8);
        bus_wdata   = 32'h0;
        bus_wr      = 1'b1;
        fault_ctx   = 2'd1;
        fault_type  = 4'h8;
        fault_code  = 3'd1;
        fault_level = 2'd3;
        fault_addr  = 32'h5555_1234;
        fault_valid = 1'b1;
        @(posedge clk); #1;
        bus_wr      = 1'b0;
        fault_valid = 1'b0;
        rd(16 + 8, v);
        chk("R8 clear plus fault", v, sexp(4'h8, 3'd1, 2'd3));
        rd(16 + 12, v);
        chk("R8 clear plus fault addr", v, 32'h5555_1234);
        wr(16 + 8, 32'h0);

        // R11: zero-type fault ignored
        flt(1, 4'h0, 3'd4, 2'd2, 32'h7777_0000);
        rd(16 + 8, v);
        chk("R11 zero type status", v, 32'h0);
        rd(16 + 12, v);
        chk("R11 zero type address", v, 32'h0);
        chk("R11 irq", 32'(irq), 0);

        finish_run();
    end

endmodule